// File: doc/BRIEF.md
# Dual-Port Memory Contention Arbiter with Width Cascade

This block sits beside a true dual-port memory array. It decides what happens when the left and right ports both address the same word in the same period. Each port brings a chip enable, a write strobe and a word address. The block returns an active-low busy flag to each port and a per-port write enable that goes to the array.

A mode input selects the role of the device. As the master, the block decides which port wins and drives busy toward the port that loses. As a slave, it does no arbitration of its own. It takes busy from a master through dedicated inputs and uses them only to block writes. Several memory slices can therefore share one master's decision and act as a single wider word.

The arbiter is synchronous. The port whose access was already stable in the previous cycle keeps the word, and a tie in the same cycle goes to the left port. The decision is held for as long as the contention lasts. Busy flags are registered. The write gating is combinational, so a losing write is blocked in the very cycle that it collides.

Top module: `dparb_top`

## Requirements
- R1: Contention exists only when both chip enables are high and the two addresses are equal. Without contention, both busy outputs read 1 after the next clock edge, and each write enable equals that port's chip enable AND its write strobe.
- R2: When contention arises because one port moves onto an address that the other port already holds, the moving port loses. In master mode the losing port's busy output goes to 0 at the next edge.
- R3: When contention arises because one port raises its chip enable onto an address that the other, already enabled, port holds, the newly enabled port loses.
- R4: When both ports arrive in the same cycle (neither port was stable in the previous cycle), the left port wins and the right port loses. Both busy outputs are never 0 at the same time.
- R5: Once a winner has been decided, it is kept for every cycle in which the contention continues. This holds even when both ports move together to a new common address.
- R6: Busy returns to 1 at the edge after the addresses stop matching, or after either chip enable (including the winner's) drops.
- R7: Busy outputs are active low and registered: they change only at a clock edge, following the inputs of the preceding cycle. An asynchronous reset forces both to 1.
- R8: In master mode (master_mode = 1), the loser's write enable is 0 in the same cycle as the contention. The winner's write enable follows its chip enable AND write strobe.
- R9: In slave mode (master_mode = 0), both busy outputs stay 1 and no arbitration is made. A port whose busy input is 0 has its write enable forced to 0, and a port whose busy input is 1 writes normally.
- R10: In master mode, the busy inputs have no effect on the write enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = master (arbitrates), 0 = slave (follows busy inputs) |
| l_ce | input | 1 | Left port chip enable, active high |
| l_we | input | 1 | Left port write strobe, active high |
| l_addr | input | AW | Left port word address |
| r_ce | input | 1 | Right port chip enable, active high |
| r_we | input | 1 | Right port write strobe, active high |
| r_addr | input | AW | Right port word address |
| l_busy_in_n | input | 1 | Left busy from the master, active low, used in slave mode |
| r_busy_in_n | input | 1 | Right busy from the master, active low, used in slave mode |
| l_busy_n | output | 1 | Left busy, active low, registered |
| r_busy_n | output | 1 | Right busy, active low, registered |
| l_wr_en | output | 1 | Left write enable to the array |
| r_wr_en | output | 1 | Right write enable to the array |

## Verification
The bench targets the arrival-order corners and the mode corners:

- **Arrival order.** An address-driven collision and a chip-enable-driven collision are each run in both directions. A design that ignored arrival order would hand the word to the same side every time.
- **Ties.** A same-cycle tie checks the fixed left-wins rule. A broken tie rule would block both writers or neither.
- **Holding the decision.** Both ports jump together to a new shared address, and the bench checks that the earlier winner keeps the word. A design that re-decided there would flip ownership in the middle of an access.
- **Release and reset.** Release is checked after a mismatch, after the loser drops its enable and after the winner drops its enable. A reset is applied in the middle of a contention. A leaky design would leave busy stuck low.
- **Modes.** In slave mode the bench toggles each busy input and checks that the write enables follow. In master mode it drives the busy inputs low and checks that they change nothing. A design with confused modes would either block writes wrongly or let colliding writes reach the array.

// File: rtl/dparb_pkg.sv
package dparb_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   l_busy_n;
        logic   r_busy_n;
    } core_st_t;

    localparam int unsigned NPORT = 2;
    localparam int unsigned PL    = 0;
    localparam int unsigned PR    = 1;

endpackage

// File: rtl/dparb_arrival.sv
module dparb_arrival #(
    parameter int unsigned AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic [AW-1:0] addr,
    output logic          stable
);
    typedef struct packed {
        logic          ce;
        logic [AW-1:0] addr;
    } arr_st_t;

    arr_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ce   = ce;
        st_d.addr = addr;
        stable    = st_q.ce && ce && (st_q.addr == addr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    stable_needs_prior_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stable |-> (ce && $past(ce) && addr == $past(addr)));
endmodule

// File: rtl/dparb_core.sv
module dparb_core
    import dparb_pkg::*;
#(
    parameter int unsigned AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_mode,
    input  logic          l_ce,
    input  logic [AW-1:0] l_addr,
    input  logic          r_ce,
    input  logic [AW-1:0] r_addr,
    input  logic          l_stable,
    input  logic          r_stable,
    output logic          l_lose,
    output logic          r_lose,
    output logic          l_busy_n,
    output logic          r_busy_n
);
    core_st_t st_d, st_q;
    logic     match;

    always_comb begin
        st_d  = st_q;
        match = l_ce && r_ce && (l_addr == r_addr);
        if (!master_mode || !match) begin
            st_d.owner = OWN_NONE;
        end else if (st_q.owner == OWN_NONE) begin
            if (r_stable && !l_stable) st_d.owner = OWN_RIGHT;
            else                       st_d.owner = OWN_LEFT;
        end
        l_lose        = (st_d.owner == OWN_RIGHT);
        r_lose        = (st_d.owner == OWN_LEFT);
        st_d.l_busy_n = !l_lose;
        st_d.r_busy_n = !r_lose;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{owner: OWN_NONE, l_busy_n: 1'b1, r_busy_n: 1'b1};
        else        st_q <= st_d;
    end

    assign l_busy_n = st_q.l_busy_n;
    assign r_busy_n = st_q.r_busy_n;

    // R4
    one_loser_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy_n || r_busy_n));

    // R1
    no_match_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_ce && r_ce && l_addr == r_addr) |=> (l_busy_n && r_busy_n));

    // R9
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |=> (l_busy_n && r_busy_n));

    // R5
    hold_left_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n && master_mode && l_ce && r_ce && l_addr == r_addr) |=> !l_busy_n);

    // R5
    hold_right_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_busy_n && master_mode && l_ce && r_ce && l_addr == r_addr) |=> !r_busy_n);
endmodule

// File: rtl/dparb_wgate.sv
module dparb_wgate
    import dparb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_mode,
    input  logic [NPORT-1:0] ce,
    input  logic [NPORT-1:0] we,
    input  logic [NPORT-1:0] lose,
    input  logic [NPORT-1:0] busy_in_n,
    output logic [NPORT-1:0] wr_en
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic block;
        always_comb begin
            block    = master_mode ? lose[p] : !busy_in_n[p];
            wr_en[p] = ce[p] && we[p] && !block;
        end

        // R9
        slave_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!master_mode && !busy_in_n[p]) |-> !wr_en[p]);

        // R8
        loser_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (master_mode && lose[p]) |-> !wr_en[p]);
    end
endmodule

// File: rtl/dparb_top.sv
module dparb_top
    import dparb_pkg::*;
#(
    parameter int unsigned AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_mode,
    input  logic          l_ce,
    input  logic          l_we,
    input  logic [AW-1:0] l_addr,
    input  logic          r_ce,
    input  logic          r_we,
    input  logic [AW-1:0] r_addr,
    input  logic          l_busy_in_n,
    input  logic          r_busy_in_n,
    output logic          l_busy_n,
    output logic          r_busy_n,
    output logic          l_wr_en,
    output logic          r_wr_en
);
    logic [NPORT-1:0]         ce_v, we_v, stable_v, lose_v, bin_v, wen_v;
    logic [NPORT-1:0][AW-1:0] addr_v;

    assign ce_v   = {r_ce, l_ce};
    assign we_v   = {r_we, l_we};
    assign bin_v  = {r_busy_in_n, l_busy_in_n};
    assign addr_v = {r_addr, l_addr};

    for (genvar p = 0; p < NPORT; p++) begin : g_arr
        dparb_arrival #(.AW(AW)) arr_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .ce     (ce_v[p]),
            .addr   (addr_v[p]),
            .stable (stable_v[p])
        );
    end

    dparb_core #(.AW(AW)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .l_ce        (l_ce),
        .l_addr      (l_addr),
        .r_ce        (r_ce),
        .r_addr      (r_addr),
        .l_stable    (stable_v[PL]),
        .r_stable    (stable_v[PR]),
        .l_lose      (lose_v[PL]),
        .r_lose      (lose_v[PR]),
        .l_busy_n    (l_busy_n),
        .r_busy_n    (r_busy_n)
    );

    dparb_wgate wgate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .ce          (ce_v),
        .we          (we_v),
        .lose        (lose_v),
        .busy_in_n   (bin_v),
        .wr_en       (wen_v)
    );

    assign l_wr_en = wen_v[PL];
    assign r_wr_en = wen_v[PR];

    // R10
    master_ignores_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && !(l_ce && r_ce && l_addr == r_addr)) |-> (l_wr_en == (l_ce && l_we)));
endmodule

// File: tb/dparb_top_tb_top.sv
module dparb_top_tb_top;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_in_n = 1, r_busy_in_n = 1;
    logic          l_busy_n, r_busy_n, l_wr_en, r_wr_en;
    int            checks = 0;
    int            errors = 0;
    bit            done = 0;

    always #2.5 clk = ~clk;

    dparb_top #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
        .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_en(l_wr_en), .r_wr_en(r_wr_en)
    );

    typedef struct packed {
        logic [3:0]    tag;
        logic          mode;
        logic          lce, lwe;
        logic [AW-1:0] laddr;
        logic          rce, rwe;
        logic [AW-1:0] raddr;
        logic          lbin, rbin;
        logic          elw, erw, elb, erb;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 1'b1, 1'b0,1'b0,15'd0, 1'b0,1'b0,15'd0, 1'b1,1'b1, 1'b0,1'b0,1'b1,1'b1}, // R1 idle
        '{4'd1, 1'b1, 1'b1,1'b1,15'd5, 1'b1,1'b0,15'd9, 1'b1,1'b1, 1'b1,1'b0,1'b1,1'b1}, // R1 no match
        '{4'd2, 1'b1, 1'b1,1'b1,15'd5, 1'b1,1'b1,15'd5, 1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0}, // R2 right moves in
        '{4'd5, 1'b1, 1'b1,1'b1,15'd5, 1'b1,1'b1,15'd5, 1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0}, // R5 hold
        '{4'd10,1'b1, 1'b1,1'b1,15'd5, 1'b1,1'b1,15'd6, 1'b0,1'b0, 1'b1,1'b1,1'b1,1'b1}, // R10 / R6 mismatch
        '{4'd1, 1'b1, 1'b1,1'b0,15'd3, 1'b0,1'b0,15'd6, 1'b1,1'b1, 1'b0,1'b0,1'b1,1'b1}, // R1 read only
        '{4'd1, 1'b1, 1'b0,1'b0,15'd3, 1'b1,1'b1,15'd7, 1'b1,1'b1, 1'b0,1'b1,1'b1,1'b1}, // R1
        '{4'd3, 1'b1, 1'b1,1'b1,15'd7, 1'b1,1'b1,15'd7, 1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1}, // R3 left enables late
        '{4'd6, 1'b1, 1'b0,1'b1,15'd7, 1'b1,1'b1,15'd7, 1'b1,1'b1, 1'b0,1'b1,1'b1,1'b1}, // R6 loser ce drop
        '{4'd1, 1'b1, 1'b0,1'b0,15'd0, 1'b0,1'b0,15'd0, 1'b1,1'b1, 1'b0,1'b0,1'b1,1'b1}, // R1
        '{4'd4, 1'b1, 1'b1,1'b1,15'd2, 1'b1,1'b1,15'd2, 1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0}, // R4 tie
        '{4'd6, 1'b1, 1'b0,1'b1,15'd2, 1'b1,1'b1,15'd2, 1'b1,1'b1, 1'b0,1'b1,1'b1,1'b1}, // R6 winner ce drop
        '{4'd3, 1'b1, 1'b1,1'b1,15'd2, 1'b1,1'b1,15'd2, 1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1}, // R3 right held
        '{4'd5, 1'b1, 1'b1,1'b1,15'd4, 1'b1,1'b1,15'd4, 1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1}, // R5 joint move
        '{4'd9, 1'b0, 1'b1,1'b1,15'd4, 1'b1,1'b1,15'd4, 1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1}, // R9 slave free
        '{4'd9, 1'b0, 1'b1,1'b1,15'd4, 1'b1,1'b1,15'd4, 1'b0,1'b1, 1'b0,1'b1,1'b1,1'b1}, // R9 left blocked
        '{4'd9, 1'b0, 1'b1,1'b1,15'd4, 1'b1,1'b1,15'd4, 1'b1,1'b0, 1'b1,1'b0,1'b1,1'b1}, // R9 right blocked
        '{4'd9, 1'b0, 1'b1,1'b0,15'd4, 1'b1,1'b0,15'd4, 1'b0,1'b0, 1'b0,1'b0,1'b1,1'b1}, // R9 reads
        '{4'd4, 1'b1, 1'b1,1'b1,15'd4, 1'b1,1'b1,15'd4, 1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0}  // R4 both stable
    };

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7 reset state
        chk("R7", "l_busy_n in reset", l_busy_n, 1'b1);
        chk("R7", "r_busy_n in reset", r_busy_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string req;
            req = $sformatf("R%0d", VECS[i].tag);
            master_mode = VECS[i].mode;
            l_ce = VECS[i].lce;  l_we = VECS[i].lwe;  l_addr = VECS[i].laddr;
            r_ce = VECS[i].rce;  r_we = VECS[i].rwe;  r_addr = VECS[i].raddr;
            l_busy_in_n = VECS[i].lbin;  r_busy_in_n = VECS[i].rbin;
            #1;
            chk(req, $sformatf("v%0d l_wr_en", i), l_wr_en, VECS[i].elw);
            chk(req, $sformatf("v%0d r_wr_en", i), r_wr_en, VECS[i].erw);
            @(posedge clk);
            #1;
            chk(req, $sformatf("v%0d l_busy_n", i), l_busy_n, VECS[i].elb);
            chk(req, $sformatf("v%0d r_busy_n", i), r_busy_n, VECS[i].erb);
            @(negedge clk);
        end

        // R7: busy is registered, not visible before the edge
        master_mode = 1; l_ce = 1; l_we = 1; l_addr = 15'd11; r_ce = 0; r_we = 0;
        @(negedge clk);
        r_ce = 1; r_we = 1; r_addr = 15'd11;
        #1;
        chk("R7", "r_busy_n before edge", r_busy_n, 1'b1);
        chk("R8", "r_wr_en same cycle", r_wr_en, 1'b0);
        @(posedge clk); #1;
        chk("R7", "r_busy_n after edge", r_busy_n, 1'b0);
        @(negedge clk);
        // R7: async reset mid-contention
        rst_n = 1'b0;
        #1;
        chk("R7", "r_busy_n on async reset", r_busy_n, 1'b1);
        chk("R7", "l_busy_n on async reset", l_busy_n, 1'b1);
        @(negedge clk);
        l_ce = 0; r_ce = 0; l_we = 0; r_we = 0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6", "l_busy_n idle after reset", l_busy_n, 1'b1);
        chk("R6", "r_busy_n idle after reset", r_busy_n, 1'b1);
        finish_run();
    end
endmodule